// File: doc/BRIEF.md
# CAN Selective Wake Frame Matcher

This block sits behind a CAN frame decoder and decides whether a received frame is the programmed wake-up frame. The decoder hands it the frame's identifier, format flags, length code and payload. A frame-end strobe marks a frame that was received correctly, and a separate strobe marks a reception error. A configuration bank held elsewhere supplies the identifier to look for, a per-bit identifier mask, an optional payload filter, an FD handling option and an error threshold.

The identifier is compared bit by bit. A mask bit of 1 removes that bit from the comparison. Standard frames compare only the low 11 bits, and extended frames compare all 29. When the payload filter is on, the length code must also match. The configured payload bytes then act as bit selectors, and one selected bit that is set anywhere in the valid payload is enough to wake. Reception errors, and FD frames that are not passed over, raise a saturating error counter. Correct frames lower it. A sticky overflow flag is set once the counter goes past the threshold.

Matching is armed by a dedicated arm strobe. Any change to the configuration disarms it, so arming has to come last.

Top module: `canWakeMatch`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `wakePulse`, `errCount` and `errOverflow` and disarms the filter. While disarmed, a frame that would otherwise match produces no wake.
- R2: The identifier matches only when `frameIde` equals `cfgIde` and every identifier bit whose `cfgIdMask` bit is 0 equals the corresponding `cfgId` bit. With IDE=0 only bits 10:0 take part and bits 28:11 of both sides are ignored. With IDE=1 bits 28:0 take part.
- R3: With `cfgDataMaskEn`=0, an identifier match alone is a hit, whatever the length code and payload.
- R4: With `cfgDataMaskEn`=1, a hit also needs `frameDlc` equal to `cfgDlc`, and at least one bit set in both `frameData` and `cfgData` within the valid bytes. Byte i occupies bits 8i+7:8i, and bytes 0 to min(DLC,8)-1 are valid.
- R5: `wakePulse` is high for exactly the one cycle after a clock edge that samples `frameValid`=1 together with `frameErr`=0, `frameFd`=0, the filter armed and a hit.
- R6: With `cfgFdPassive`=1, a frame with `frameFd`=1 is ignored: it gives no wake and leaves `errCount` unchanged.
- R7: With `cfgFdPassive`=0, a frame with `frameFd`=1 gives no wake and counts as a reception error.
- R8: A `frameErr` strobe, or an error from R7, raises `errCount` by one in the next cycle, saturating at 2^CNT_W-1. `frameErr` takes priority over a `frameValid` sampled at the same edge.
- R9: A correctly received non-FD frame lowers `errCount` by one in the next cycle when it is above 0. At 0 the counter stays at 0.
- R10: `errOverflow` rises in the same cycle that `errCount` first exceeds `cfgThreshold`, and it stays high until reset.
- R11: A `cfgArm` strobe arms the filter from the next cycle on. A `cfgChange` strobe disarms it, and it wins over `cfgArm` when both are sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frameValid | input | 1 | Frame-end strobe for a correctly received frame |
| frameErr | input | 1 | Reception error strobe |
| frameId | input | 29 | Received identifier, right-justified |
| frameIde | input | 1 | Received frame uses the extended identifier |
| frameDlc | input | 4 | Received length code |
| frameData | input | 64 | Received payload, byte i at bits 8i+7:8i |
| frameFd | input | 1 | Received frame is in FD format |
| cfgId | input | 29 | Wake identifier, right-justified |
| cfgIdMask | input | 29 | Identifier mask, 1 means the bit is ignored |
| cfgIde | input | 1 | Wake frame uses the extended identifier |
| cfgDlc | input | 4 | Length code required when the payload filter is on |
| cfgDataMaskEn | input | 1 | Payload filter enable |
| cfgData | input | 64 | Payload bit selectors |
| cfgFdPassive | input | 1 | Ignore FD frames instead of counting them as errors |
| cfgThreshold | input | 6 | Error threshold (31 by convention) |
| cfgChange | input | 1 | Strobe: a configuration field was written |
| cfgArm | input | 1 | Strobe: arm the filter |
| wakePulse | output | 1 | One-cycle wake indication |
| errOverflow | output | 1 | Sticky error overflow flag |
| errCount | output | 6 | Current error count |

## Verification
Every result is registered once. `wakePulse`, `errCount` and `errOverflow` all reflect the inputs sampled at the previous rising edge, and a change of arming affects frames sampled from the following edge on. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge from the same sampled inputs, and all three outputs are compared with the model on every falling edge, half a cycle after they settle. Because the comparison runs every cycle, a wake that lasts too long, comes a cycle early or late, or a counter step that is missed, shows up as a mismatch in the cycle where it happens.

// File: rtl/canWakePkg.sv
package canWakePkg;
  typedef struct packed {
    logic cntInc;
    logic cntDec;
  } ctlStrobes_t;
endpackage

// File: rtl/canWakeDatapath.sv
module canWakeDatapath
  import canWakePkg::*;
#(
  parameter int ID_W       = 29,
  parameter int STD_W      = 11,
  parameter int DLC_W      = 4,
  parameter int DATA_BYTES = 8,
  parameter int CNT_W      = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ID_W-1:0]         frameId,
  input  logic                    frameIde,
  input  logic [DLC_W-1:0]        frameDlc,
  input  logic [DATA_BYTES*8-1:0] frameData,
  input  logic [ID_W-1:0]         cfgId,
  input  logic [ID_W-1:0]         cfgIdMask,
  input  logic                    cfgIde,
  input  logic [DLC_W-1:0]        cfgDlc,
  input  logic                    cfgDataMaskEn,
  input  logic [DATA_BYTES*8-1:0] cfgData,
  input  logic [CNT_W-1:0]        cfgThreshold,
  input  ctlStrobes_t             strobes,
  output logic                    frameHit,
  output logic [CNT_W-1:0]        errCount,
  output logic                    errOverflow
);
  localparam logic [ID_W-1:0]  STD_CARE = {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [ID_W-1:0]       idCare;
  logic                  idMatch;
  logic [DATA_BYTES-1:0] byteHit;
  logic                  dataMatch;
  logic [CNT_W-1:0]      countNext;
  logic                  pastOk;

  // identifier compare: width follows the frame format, masked bits drop out
  assign idCare  = ~cfgIdMask & (frameIde ? {ID_W{1'b1}} : STD_CARE);
  assign idMatch = (frameIde == cfgIde) && (((frameId ^ cfgId) & idCare) == '0);

  // payload filter: one selected, set bit in a byte inside the length is enough
  for (genvar g = 0; g < DATA_BYTES; g++) begin : gByte
    assign byteHit[g] = (32'(frameDlc) > g) && (|(frameData[8*g +: 8] & cfgData[8*g +: 8]));
  end

  assign dataMatch = (frameDlc == cfgDlc) && (|byteHit);
  assign frameHit  = idMatch && (!cfgDataMaskEn || dataMatch);

  always_comb begin
    countNext = errCount;
    if (strobes.cntInc && errCount != CNT_MAX)  countNext = errCount + 1'b1;
    else if (strobes.cntDec && errCount != '0)  countNext = errCount - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errCount    <= '0;
      errOverflow <= 1'b0;
      pastOk      <= 1'b0;
    end else begin
      errCount    <= countNext;
      errOverflow <= errOverflow | (countNext > cfgThreshold);
      pastOk      <= 1'b1;
    end
  end

  assert_cnt_single_step_R8 : assert property (@(posedge clk) disable iff (rst || !pastOk)
    (errCount == $past(errCount)) || (errCount == $past(errCount) + 1'b1) ||
    (errCount == $past(errCount) - 1'b1));

  assert_ovf_sticky_R10 : assert property (@(posedge clk) disable iff (rst || !pastOk)
    $past(errOverflow) |-> errOverflow);

  assert_ovf_needs_excess_R10 : assert property (@(posedge clk) disable iff (rst || !pastOk)
    $rose(errOverflow) |-> (errCount > cfgThreshold));

  assert_dec_floor_R9 : assert property (@(posedge clk) disable iff (rst || !pastOk)
    ($past(errCount) == '0 && !$past(strobes.cntInc)) |-> (errCount == '0));
endmodule

// File: rtl/canWakeControl.sv
module canWakeControl
  import canWakePkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        frameValid,
  input  logic        frameErr,
  input  logic        frameFd,
  input  logic        cfgFdPassive,
  input  logic        cfgChange,
  input  logic        cfgArm,
  input  logic        frameHit,
  output ctlStrobes_t strobes,
  output logic        wakePulse
);
  logic armedQ;
  logic evErr;
  logic evGood;
  logic pastOk;

  // an FD frame is an error unless it is passed over
  assign evErr  = frameErr | (frameValid & frameFd & ~cfgFdPassive);
  assign evGood = frameValid & ~frameErr & ~frameFd;

  assign strobes.cntInc = evErr;
  assign strobes.cntDec = evGood;

  always_ff @(posedge clk) begin
    if (rst) begin
      armedQ    <= 1'b0;
      wakePulse <= 1'b0;
      pastOk    <= 1'b0;
    end else begin
      if (cfgChange)   armedQ <= 1'b0;
      else if (cfgArm) armedQ <= 1'b1;
      wakePulse <= evGood & armedQ & frameHit;
      pastOk    <= 1'b1;
    end
  end

  assert_wake_cause_R5 : assert property (@(posedge clk) disable iff (rst || !pastOk)
    wakePulse |-> $past(frameValid && !frameErr && !frameFd && armedQ));

  assert_fd_passive_quiet_R6 : assert property (@(posedge clk) disable iff (rst)
    (frameValid && frameFd && cfgFdPassive && !frameErr) |=> !wakePulse);

  assert_strobe_exclusive_R8 : assert property (@(posedge clk) disable iff (rst)
    !(strobes.cntInc && strobes.cntDec));

  assert_change_disarms_R11 : assert property (@(posedge clk) disable iff (rst)
    cfgChange |=> !armedQ);
endmodule

// File: rtl/canWakeMatch.sv
module canWakeMatch
  import canWakePkg::*;
#(
  parameter int ID_W       = 29,
  parameter int STD_W      = 11,
  parameter int DLC_W      = 4,
  parameter int DATA_BYTES = 8,
  parameter int CNT_W      = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frameValid,
  input  logic                    frameErr,
  input  logic [ID_W-1:0]         frameId,
  input  logic                    frameIde,
  input  logic [DLC_W-1:0]        frameDlc,
  input  logic [DATA_BYTES*8-1:0] frameData,
  input  logic                    frameFd,
  input  logic [ID_W-1:0]         cfgId,
  input  logic [ID_W-1:0]         cfgIdMask,
  input  logic                    cfgIde,
  input  logic [DLC_W-1:0]        cfgDlc,
  input  logic                    cfgDataMaskEn,
  input  logic [DATA_BYTES*8-1:0] cfgData,
  input  logic                    cfgFdPassive,
  input  logic [CNT_W-1:0]        cfgThreshold,
  input  logic                    cfgChange,
  input  logic                    cfgArm,
  output logic                    wakePulse,
  output logic                    errOverflow,
  output logic [CNT_W-1:0]        errCount
);
  ctlStrobes_t strobes;
  logic        frameHit;

  canWakeControl uCtl (
    .clk(clk), .rst(rst), .frameValid(frameValid), .frameErr(frameErr),
    .frameFd(frameFd), .cfgFdPassive(cfgFdPassive), .cfgChange(cfgChange),
    .cfgArm(cfgArm), .frameHit(frameHit), .strobes(strobes), .wakePulse(wakePulse)
  );

  canWakeDatapath #(
    .ID_W(ID_W), .STD_W(STD_W), .DLC_W(DLC_W), .DATA_BYTES(DATA_BYTES), .CNT_W(CNT_W)
  ) uDp (
    .clk(clk), .rst(rst), .frameId(frameId), .frameIde(frameIde), .frameDlc(frameDlc),
    .frameData(frameData), .cfgId(cfgId), .cfgIdMask(cfgIdMask), .cfgIde(cfgIde),
    .cfgDlc(cfgDlc), .cfgDataMaskEn(cfgDataMaskEn), .cfgData(cfgData),
    .cfgThreshold(cfgThreshold), .strobes(strobes), .frameHit(frameHit),
    .errCount(errCount), .errOverflow(errOverflow)
  );
endmodule

// File: tb/canWakeMatch_test.sv
`timescale 1ns/1ps
module canWakeMatch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frameValid = 0, frameErr = 0, frameIde = 0, frameFd = 0;
  logic [28:0] frameId = '0;
  logic [3:0]  frameDlc = '0;
  logic [63:0] frameData = '0;
  logic [28:0] cfgId = '0, cfgIdMask = '0;
  logic        cfgIde = 0, cfgDataMaskEn = 0, cfgFdPassive = 0, cfgChange = 0, cfgArm = 0;
  logic [3:0]  cfgDlc = '0;
  logic [63:0] cfgData = '0;
  logic [5:0]  cfgThreshold = 6'd31;
  logic        wakePulse, errOverflow;
  logic [5:0]  errCount;

  canWakeMatch uut (.*);

  always #2.5 clk = ~clk;

  int    nCmp = 0, nBad = 0, cycles = 0;
  string curReq = "R1";
  int    expWake = 0, expCnt = 0, expOvf = 0, expArmed = 0;

  function automatic int hitRef();
    int nb;
    int any;
    if (frameIde != cfgIde) return 0;
    for (int b = 0; b < 29; b++) begin
      if (!frameIde && b >= 11) continue;
      if (!cfgIdMask[b] && frameId[b] != cfgId[b]) return 0;
    end
    if (!cfgDataMaskEn) return 1;
    if (frameDlc != cfgDlc) return 0;
    nb  = (frameDlc > 8) ? 8 : int'(frameDlc);
    any = 0;
    for (int k = 0; k < nb * 8; k++)
      if (frameData[k] && cfgData[k]) any = 1;
    return any;
  endfunction

  // behavioural reference, updated from the inputs sampled at the edge
  always @(posedge clk) begin
    int err, good;
    if (rst) begin
      expWake = 0; expCnt = 0; expOvf = 0; expArmed = 0;
    end else begin
      err  = (frameErr || (frameValid && frameFd && !cfgFdPassive)) ? 1 : 0;
      good = (frameValid && !frameErr && !frameFd) ? 1 : 0;
      expWake = (good && expArmed && hitRef() != 0) ? 1 : 0;
      if (err) begin
        if (expCnt < 63) expCnt++;
      end else if (good && expCnt > 0) expCnt--;
      if (expCnt > int'(cfgThreshold)) expOvf = 1;
      if (cfgChange) expArmed = 0;
      else if (cfgArm) expArmed = 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    nCmp++;
    if (int'(wakePulse) != expWake) begin
      nBad++; $display("FAIL %s wakePulse got %0d exp %0d", curReq, wakePulse, expWake);
    end
    nCmp++;
    if (int'(errCount) != expCnt) begin
      nBad++; $display("FAIL %s errCount got %0d exp %0d", curReq, errCount, expCnt);
    end
    nCmp++;
    if (int'(errOverflow) != expOvf) begin
      nBad++; $display("FAIL %s errOverflow got %0d exp %0d", curReq, errOverflow, expOvf);
    end
    if (cycles > 20000) begin
      nBad++;
      $display("FAIL watchdog %s got running exp finished", curReq);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [28:0] id, input logic ide, input logic [3:0] dlc,
                           input logic [63:0] data, input logic fd);
    @(negedge clk);
    frameId = id; frameIde = ide; frameDlc = dlc; frameData = data; frameFd = fd;
    frameValid = 1;
    @(negedge clk);
    frameValid = 0;
    idle(1);
  endtask

  task automatic errPulse();
    @(negedge clk); frameErr = 1;
    @(negedge clk); frameErr = 0;
  endtask

  task automatic configure(input logic [28:0] id, input logic [28:0] mask, input logic ide,
                           input logic dme, input logic [3:0] dlc, input logic [63:0] data);
    @(negedge clk);
    cfgId = id; cfgIdMask = mask; cfgIde = ide; cfgDataMaskEn = dme; cfgDlc = dlc;
    cfgData = data; cfgChange = 1;
    @(negedge clk); cfgChange = 0;
    cfgArm = 1;
    @(negedge clk); cfgArm = 0;
  endtask

  initial begin
    // R1: reset state, no wake while disarmed
    curReq = "R1";
    idle(3);
    @(negedge clk); rst = 0;
    @(negedge clk); cfgId = 29'h123; cfgChange = 1;
    @(negedge clk); cfgChange = 0;
    sendFrame(29'h123, 0, 4'd0, 64'h0, 0);

    // R11: arm then frame wakes; change and arm together leaves it disarmed
    curReq = "R11";
    configure(29'h123, 29'h0, 0, 0, 4'd0, 64'h0);
    sendFrame(29'h123, 0, 4'd2, 64'h0, 0);
    @(negedge clk); cfgChange = 1; cfgArm = 1;
    @(negedge clk); cfgChange = 0; cfgArm = 0;
    sendFrame(29'h123, 0, 4'd2, 64'h0, 0);
    @(negedge clk); cfgArm = 1;
    @(negedge clk); cfgArm = 0;

    // R2: identifier compare, masks and formats
    curReq = "R2";
    sendFrame(29'h122, 0, 4'd0, 64'h0, 0);
    sendFrame(29'h1FFFF923, 0, 4'd0, 64'h0, 0);
    sendFrame(29'h123, 1, 4'd0, 64'h0, 0);
    configure(29'h123, 29'h003, 0, 0, 4'd0, 64'h0);
    sendFrame(29'h120, 0, 4'd0, 64'h0, 0);
    sendFrame(29'h133, 0, 4'd0, 64'h0, 0);
    configure(29'h1ABCDEF5, 29'h0, 1, 0, 4'd0, 64'h0);
    sendFrame(29'h1ABCDEF5, 1, 4'd0, 64'h0, 0);
    sendFrame(29'h0ABCDEF5, 1, 4'd0, 64'h0, 0);
    sendFrame(29'h1ABCDEF5, 0, 4'd0, 64'h0, 0);

    // R3: payload ignored with the filter off
    curReq = "R3";
    configure(29'h055, 29'h0, 0, 0, 4'd3, 64'hFF);
    sendFrame(29'h055, 0, 4'd8, 64'h0, 0);
    sendFrame(29'h055, 0, 4'd1, 64'hDEAD_BEEF_0000_0000, 0);

    // R4: payload filter
    curReq = "R4";
    configure(29'h055, 29'h0, 0, 1, 4'd3, 64'h0000_0000_0004_0000);
    sendFrame(29'h055, 0, 4'd3, 64'h0000_0000_0004_0000, 0);
    sendFrame(29'h055, 0, 4'd2, 64'h0000_0000_0004_0000, 0);
    sendFrame(29'h055, 0, 4'd3, 64'h0000_0000_00FB_FFFF, 0);
    configure(29'h055, 29'h0, 0, 1, 4'd3, 64'h0000_0001_0000_0000);
    sendFrame(29'h055, 0, 4'd3, 64'h0000_0001_0000_0000, 0);
    configure(29'h055, 29'h0, 0, 1, 4'd12, 64'h8000_0000_0000_0000);
    sendFrame(29'h055, 0, 4'd12, 64'h8000_0000_0000_0000, 0);

    // R5: back-to-back frames give back-to-back single pulses
    curReq = "R5";
    configure(29'h010, 29'h0, 0, 0, 4'd0, 64'h0);
    @(negedge clk); frameId = 29'h010; frameIde = 0; frameFd = 0; frameValid = 1;
    @(negedge clk);
    @(negedge clk); frameValid = 0;
    idle(2);

    // R6 / R7: FD handling
    curReq = "R6";
    @(negedge clk); cfgFdPassive = 1; cfgChange = 1;
    @(negedge clk); cfgChange = 0; cfgArm = 1;
    @(negedge clk); cfgArm = 0;
    sendFrame(29'h010, 0, 4'd0, 64'h0, 1);
    curReq = "R7";
    @(negedge clk); cfgFdPassive = 0; cfgChange = 1;
    @(negedge clk); cfgChange = 0; cfgArm = 1;
    @(negedge clk); cfgArm = 0;
    sendFrame(29'h010, 0, 4'd0, 64'h0, 1);
    sendFrame(29'h010, 0, 4'd0, 64'h0, 1);

    // R9: good frames lower the count, floor at zero
    curReq = "R9";
    repeat (4) sendFrame(29'h010, 0, 4'd0, 64'h0, 0);

    // R8: error priority and saturation
    curReq = "R8";
    @(negedge clk); frameErr = 1; frameValid = 1; frameId = 29'h010;
    @(negedge clk); frameErr = 0; frameValid = 0;
    idle(1);
    repeat (70) errPulse();

    // R10: overflow against a small threshold, cleared only by reset
    curReq = "R10";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; cfgThreshold = 6'd3;
    repeat (3) errPulse();
    errPulse();
    repeat (4) sendFrame(29'h7FF, 0, 4'd0, 64'h0, 0);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule